// File: doc/BRIEF.md
# Frame-Pulse Timing and Channel-Strobe Generator

This block runs on a 4.096 MHz master clock. It watches an active-low frame-alignment input and decides which of two modes is in force. In bus mode all timing is generated internally. In serial mode the internal slot decode is unused, and external strobes and an external bit clock govern the data ports. Mode detection uses the frame input alone. A stream of one-clock-wide low pulses, one per 8 kHz frame, selects bus mode. An input held low, or a frame input that goes quiet, selects serial mode.

In bus mode the block divides the master clock by two to give a 2.048 MHz bit clock. It counts master clocks across a 512-clock frame of 32 eight-bit slots, and each bit cell is two master clocks long. From this count it decodes:

- two PCM channel-enable strobes, which can drive external codecs directly;
- one ADPCM word window;
- a sample point, at the three-quarter point of each bit cell;
- a launch point, at the start of each bit cell.

One select pin moves the PCM slots and the ADPCM slot together. A power-down input freezes every counter and drives the strobes inactive.

Top module: `tdm_frame_timer`

## Requirements
- R1: While powered, `bclk_o` is high in the first master clock of each bit cell and low in the second, so it runs at half the master-clock rate. While powered down it is low.
- R2: After reset the block is in serial mode: `bus_mode` is low, and all three strobes are low.
- R3: Bus mode is entered only when an accepted pulse arrives exactly one frame (512 master clocks) after a previous accepted pulse. An accepted pulse is a frame input that is low for exactly one master clock. A second pulse arriving at any other spacing leaves the block outside bus mode.
- R4: A low level on the frame input sampled on two consecutive clocks leaves bus mode at once. While the input stays low the block stays in serial mode, and the rising edge that ends a wide low is not accepted as a pulse.
- R5: In bus mode, a run of 1024 powered master clocks after the last accepted pulse with no new accepted pulse returns the block to serial mode. It is still in bus mode after 1023 such clocks.
- R6: An accepted pulse resets the frame position to zero on the clock that detects it, at any point in the frame. The position then counts up each powered clock and wraps from 511 to 0.
- R7: With `slot_sel` low, `pcm_en1` is high in slot 0, `pcm_en2` is high in slot 1, and `adpcm_win` is high in slot 2. Slot n spans frame positions 16n to 16n+15.
- R8: With `slot_sel` high, `pcm_en1` is high in slot 2, and both `pcm_en2` and `adpcm_win` are high in slot 3.
- R9: In bus mode, `launch_pt` is high in the first master clock of every bit cell and `sample_pt` is high in the second. The two are never high together.
- R10: Outside bus mode, `pcm_en1`, `pcm_en2`, `adpcm_win`, `sample_pt` and `launch_pt` are all low.
- R11: While `pwr_n` is low, the frame position, the mode and the silence count all hold. The strobes, `sample_pt`, `launch_pt` and `bclk_o` are low. When power returns, counting resumes from the held position.
- R12: `adpcm_win` is never high in slot 0 or slot 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mclk | input | 1 | 4.096 MHz master clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pwr_n | input | 1 | Power-down, active low; freezes counters |
| frame_n | input | 1 | Frame-alignment input, active-low pulse |
| slot_sel | input | 1 | Slot select: low gives slots 0/1/2, high gives slots 2/3/3 |
| bclk_o | output | 1 | Bit clock, master clock divided by two |
| bus_mode | output | 1 | High while internally timed bus mode is in force |
| pcm_en1 | output | 1 | PCM channel 1 enable strobe |
| pcm_en2 | output | 1 | PCM channel 2 enable strobe |
| adpcm_win | output | 1 | ADPCM word window |
| sample_pt | output | 1 | Input sampling point (second clock of a bit cell) |
| launch_pt | output | 1 | Output launch point (first clock of a bit cell) |

## Verification
With `slot_sel` high, the second PCM strobe and the ADPCM window decode the same slot, so both are active in the same clocks. The bench provokes this by raising the select inside a synchronised frame and stepping to slot 3. It expects both strobes high together with the correct sample and launch phase, and the first strobe low. A second collision is a realigning pulse that arrives mid-frame, at the same clock the counter would otherwise advance. The bench judges it by checking that the slot-0 strobe appears at once, not 512 clocks later.

// File: rtl/tdm_frame_timer_pkg.sv
package tdm_frame_timer_pkg;

  typedef enum logic [1:0] {
    MODE_HUNT = 2'd0,
    MODE_ARM  = 2'd1,
    MODE_BUS  = 2'd2
  } mode_e;

  // slot number of a frame position
  function automatic int slot_of(input int pos, input int clks_per_slot);
    return pos / clks_per_slot;
  endfunction

  // master-clock phase inside a bit cell
  function automatic int phase_of(input int pos, input int clks_per_bit);
    return pos % clks_per_bit;
  endfunction

  // slot used by a strobe: base slot plus the shift when the select is high
  function automatic int moved_slot(input int base, input logic sel, input int shift);
    return sel ? base + shift : base;
  endfunction

endpackage

// File: rtl/tdm_frame_detect.sv
module tdm_frame_detect (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic frame_n,
  output logic pulse_ok,
  output logic wide_low
);
  logic fq1, fq2;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fq1 <= 1'b1;
      fq2 <= 1'b1;
    end else if (run) begin
      fq1 <= frame_n;
      fq2 <= fq1;
    end
  end

  // high, one low sample, high again: a pulse exactly one clock wide
  assign pulse_ok = frame_n & ~fq1 & fq2;
  // two low samples in a row: wide low or tied low
  assign wide_low = ~frame_n & ~fq1;

endmodule

// File: rtl/tdm_frame_counter.sv
module tdm_frame_counter #(
  parameter int FRAME_CLKS = 512,
  localparam int POS_W = $clog2(FRAME_CLKS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             realign,
  output logic [POS_W-1:0] pos,
  output logic             at_end
);
  localparam logic [POS_W-1:0] LAST = POS_W'(FRAME_CLKS - 1);

  assign at_end = (pos == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       pos <= '0;
    else if (run) begin
      if (realign)     pos <= '0;
      else if (at_end) pos <= '0;
      else             pos <= pos + 1'b1;
    end
  end

endmodule

// File: rtl/tdm_mode_fsm.sv
module tdm_mode_fsm
  import tdm_frame_timer_pkg::*;
#(
  parameter int FRAME_CLKS = 512,
  localparam int GAP_W = $clog2(2 * FRAME_CLKS)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic pulse_ok,
  input  logic wide_low,
  input  logic at_end,
  output logic bus_mode
);
  localparam logic [GAP_W-1:0] GAP_LAST = GAP_W'(2 * FRAME_CLKS - 1);

  mode_e            mode_q;
  logic [GAP_W-1:0] gap_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= MODE_HUNT;
      gap_q  <= '0;
    end else if (run) begin
      case (mode_q)
        MODE_HUNT: if (pulse_ok) mode_q <= MODE_ARM;
        MODE_ARM: begin
          if (wide_low)    mode_q <= MODE_HUNT;
          else if (at_end) begin
            mode_q <= pulse_ok ? MODE_BUS : MODE_HUNT;
            gap_q  <= '0;
          end
        end
        MODE_BUS: begin
          if (wide_low)                mode_q <= MODE_HUNT;
          else if (pulse_ok)           gap_q  <= '0;
          else if (gap_q == GAP_LAST)  mode_q <= MODE_HUNT;
          else                         gap_q  <= gap_q + 1'b1;
        end
        default: mode_q <= MODE_HUNT;
      endcase
    end
  end

  assign bus_mode = (mode_q == MODE_BUS);

endmodule

// File: rtl/tdm_slot_decode.sv
module tdm_slot_decode
  import tdm_frame_timer_pkg::*;
#(
  parameter int FRAME_CLKS    = 512,
  parameter int CLKS_PER_SLOT = 16,
  parameter int CLKS_PER_BIT  = 2,
  parameter int ALT_SHIFT     = 2,
  localparam int POS_W  = $clog2(FRAME_CLKS),
  localparam int SLOT_W = $clog2(FRAME_CLKS / CLKS_PER_SLOT)
) (
  input  logic [POS_W-1:0]  pos,
  input  logic              active,
  input  logic              run,
  input  logic              sel,
  output logic [SLOT_W-1:0] slot_idx,
  output logic              bclk_o,
  output logic              en1,
  output logic              en2,
  output logic              adp,
  output logic              samp,
  output logic              launch
);
  localparam int SAMPLE_PHASE = (3 * CLKS_PER_BIT) / 4;
  localparam int HALF_BIT     = CLKS_PER_BIT / 2;

  int slot_i, phase_i;
  logic live;

  always_comb begin
    slot_i  = slot_of(int'(pos), CLKS_PER_SLOT);
    phase_i = phase_of(int'(pos), CLKS_PER_BIT);
    live    = active & run;
    slot_idx = SLOT_W'(slot_i);
    bclk_o  = run & (phase_i < HALF_BIT);
    en1     = live & (slot_i == moved_slot(0, sel, ALT_SHIFT));
    en2     = live & (slot_i == moved_slot(1, sel, ALT_SHIFT));
    adp     = live & (slot_i == moved_slot(2, sel, ALT_SHIFT - 1));
    samp    = live & (phase_i == SAMPLE_PHASE);
    launch  = live & (phase_i == 0);
  end

endmodule

// File: rtl/tdm_frame_timer.sv
module tdm_frame_timer #(
  parameter int SLOTS         = 32,
  parameter int BITS_PER_SLOT = 8,
  parameter int CLKS_PER_BIT  = 2,
  parameter int ALT_SHIFT     = 2,
  localparam int CLKS_PER_SLOT = BITS_PER_SLOT * CLKS_PER_BIT,
  localparam int FRAME_CLKS    = SLOTS * CLKS_PER_SLOT,
  localparam int POS_W         = $clog2(FRAME_CLKS),
  localparam int SLOT_W        = $clog2(SLOTS)
) (
  input  logic mclk,
  input  logic rst_n,
  input  logic pwr_n,
  input  logic frame_n,
  input  logic slot_sel,
  output logic bclk_o,
  output logic bus_mode,
  output logic pcm_en1,
  output logic pcm_en2,
  output logic adpcm_win,
  output logic sample_pt,
  output logic launch_pt
);
  logic              pulse_ok_w, wide_low_w, at_end_w;
  logic [POS_W-1:0]  pos_q;
  logic [SLOT_W-1:0] slot_w;

  tdm_frame_detect det_i (
    .clk(mclk), .rst_n(rst_n), .run(pwr_n), .frame_n(frame_n),
    .pulse_ok(pulse_ok_w), .wide_low(wide_low_w)
  );

  tdm_frame_counter #(.FRAME_CLKS(FRAME_CLKS)) cnt_i (
    .clk(mclk), .rst_n(rst_n), .run(pwr_n), .realign(pulse_ok_w),
    .pos(pos_q), .at_end(at_end_w)
  );

  tdm_mode_fsm #(.FRAME_CLKS(FRAME_CLKS)) fsm_i (
    .clk(mclk), .rst_n(rst_n), .run(pwr_n), .pulse_ok(pulse_ok_w),
    .wide_low(wide_low_w), .at_end(at_end_w), .bus_mode(bus_mode)
  );

  tdm_slot_decode #(
    .FRAME_CLKS(FRAME_CLKS), .CLKS_PER_SLOT(CLKS_PER_SLOT),
    .CLKS_PER_BIT(CLKS_PER_BIT), .ALT_SHIFT(ALT_SHIFT)
  ) dec_i (
    .pos(pos_q), .active(bus_mode), .run(pwr_n), .sel(slot_sel),
    .slot_idx(slot_w), .bclk_o(bclk_o), .en1(pcm_en1), .en2(pcm_en2),
    .adp(adpcm_win), .samp(sample_pt), .launch(launch_pt)
  );

endmodule

// File: rtl/tdm_frame_timer_chk.sv
module tdm_frame_timer_chk #(
  parameter int POS_W  = 9,
  parameter int SLOT_W = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              pwr_n,
  input logic              bus_mode,
  input logic              pcm_en1,
  input logic              pcm_en2,
  input logic              adpcm_win,
  input logic              sample_pt,
  input logic              launch_pt,
  input logic              pulse_ok,
  input logic [POS_W-1:0]  pos,
  input logic [SLOT_W-1:0] slot_idx
);
  // R12
  adpcm_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    adpcm_win |-> (slot_idx >= SLOT_W'(2)));

  // R10
  serial_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_mode |-> !(pcm_en1 || pcm_en2 || adpcm_win || sample_pt || launch_pt));

  // R11
  pd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pwr_n |=> (pos == $past(pos)));

  // R6
  realign_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pulse_ok && pwr_n) |=> (pos == '0));

  // R3
  bus_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_mode) |-> $past(pulse_ok));

  // R7
  pcm_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({pcm_en1, pcm_en2}));

  // R9
  phase_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(sample_pt && launch_pt));

endmodule

bind tdm_frame_timer tdm_frame_timer_chk #(.POS_W(POS_W), .SLOT_W(SLOT_W)) chk_i (
  .clk(mclk), .rst_n(rst_n), .pwr_n(pwr_n), .bus_mode(bus_mode),
  .pcm_en1(pcm_en1), .pcm_en2(pcm_en2), .adpcm_win(adpcm_win),
  .sample_pt(sample_pt), .launch_pt(launch_pt), .pulse_ok(pulse_ok_w),
  .pos(pos_q), .slot_idx(slot_w)
);

// File: tb/tdm_frame_timer_tb_top.sv
module tdm_frame_timer_tb_top;
  localparam int F = 512;

  logic clk = 1'b0;
  logic rst_n, pwr_n, frame_n, slot_sel;
  logic bclk_o, bus_mode, pcm_en1, pcm_en2, adpcm_win, sample_pt, launch_pt;

  int checks = 0;
  int errors = 0;
  int bpos   = 0;
  int since  = 0;

  always #10 clk = ~clk;

  tdm_frame_timer dut_i (
    .mclk(clk), .rst_n(rst_n), .pwr_n(pwr_n), .frame_n(frame_n),
    .slot_sel(slot_sel), .bclk_o(bclk_o), .bus_mode(bus_mode),
    .pcm_en1(pcm_en1), .pcm_en2(pcm_en2), .adpcm_win(adpcm_win),
    .sample_pt(sample_pt), .launch_pt(launch_pt)
  );

  // {position, select, expected {en1,en2,adp,sample,launch,bclk}}
  localparam logic [15:0] VEC [0:8] = '{
    {9'd0,   1'b0, 6'b100011},   // R7 slot 0
    {9'd17,  1'b0, 6'b010100},   // R7 slot 1, R9 sample
    {9'd33,  1'b0, 6'b001100},   // R7 slot 2
    {9'd40,  1'b1, 6'b100011},   // R8 slot 2
    {9'd48,  1'b1, 6'b011011},   // R8 slot 3 collision
    {9'd63,  1'b1, 6'b011100},   // R8 slot 3 last clock
    {9'd64,  1'b0, 6'b000011},   // R1 idle slot
    {9'd100, 1'b1, 6'b000011},   // R8 idle slot
    {9'd511, 1'b0, 6'b000100}    // R6 last position
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic step();
    logic en;
    en = pwr_n;
    @(negedge clk);
    if (en) begin
      bpos = (bpos + 1) % F;
      since++;
    end
  endtask

  task automatic pulse();
    frame_n = 1'b0;
    step();
    frame_n = 1'b1;
    step();
    bpos  = 0;
    since = 0;
  endtask

  function automatic logic [5:0] outs();
    return {pcm_en1, pcm_en2, adpcm_win, sample_pt, launch_pt, bclk_o};
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; pwr_n = 1'b1; frame_n = 1'b1; slot_sel = 1'b0;
    repeat (3) @(negedge clk);
    chk("R2 bus_mode in reset", 32'(bus_mode), 32'd0);
    chk("R2 strobes in reset", 32'({pcm_en1, pcm_en2, adpcm_win}), 32'd0);
    rst_n = 1'b1;
    bpos = 0;
    step();
    chk("R1 bclk odd phase", 32'(bclk_o), 32'd0);
    step();
    chk("R1 bclk even phase", 32'(bclk_o), 32'd1);
    chk("R10 serial strobes low in slot 0", 32'(outs() & 6'b111110), 32'd0);

    // R3 first pulse arms, a late second pulse does not enter bus mode
    pulse();
    chk("R3 one pulse only", 32'(bus_mode), 32'd0);
    repeat (F - 1) step();
    pulse();
    chk("R3 late second pulse", 32'(bus_mode), 32'd0);
    repeat (F - 2) step();
    pulse();
    chk("R3 on-time second pulse", 32'(bus_mode), 32'd1);

    // table walk within one synchronised frame
    for (int i = 0; i < 9; i++) begin
      slot_sel = VEC[i][6];
      while (bpos != int'(VEC[i][15:7])) step();
      chk($sformatf("R7/R8/R9 vector %0d", i), 32'(outs()), 32'(VEC[i][5:0]));
    end

    // R6 wrap and mid-frame realignment
    slot_sel = 1'b0;
    step();
    chk("R6 wrap to slot 0", 32'(outs()), 32'b100011);
    while (bpos != 100) step();
    pulse();
    chk("R6 realign to slot 0", 32'(outs()), 32'b100011);
    chk("R6 still bus", 32'(bus_mode), 32'd1);

    // R11 power-down freezes position
    while (bpos != 20) step();
    pwr_n = 1'b0;
    #1;
    chk("R11 outputs low in power-down", 32'(outs()), 32'd0);
    repeat (10) step();
    chk("R11 outputs held low", 32'(outs()), 32'd0);
    pwr_n = 1'b1;
    #1;
    chk("R11 resumes at held position", 32'(outs()), 32'b010011);
    step();
    chk("R11 next position", 32'(outs()), 32'b010100);

    // R5 silence timeout
    while (since != 2 * F - 1) step();
    chk("R5 still bus after 1023", 32'(bus_mode), 32'd1);
    step();
    chk("R5 left bus after 1024", 32'(bus_mode), 32'd0);
    chk("R10 strobes low after exit", 32'(outs() & 6'b111110), 32'd0);

    // R4 wide low exits immediately
    pulse();
    repeat (F - 2) step();
    pulse();
    chk("R4 bus re-entered", 32'(bus_mode), 32'd1);
    frame_n = 1'b0;
    step();
    chk("R4 one low sample keeps bus", 32'(bus_mode), 32'd1);
    step();
    chk("R4 wide low leaves bus", 32'(bus_mode), 32'd0);
    repeat (5) step();
    chk("R4 held low stays serial", 32'(bus_mode), 32'd0);
    frame_n = 1'b1;
    repeat (F + 4) step();
    chk("R4 wide low end not a pulse", 32'(bus_mode), 32'd0);
    chk("R10 serial outputs quiet", 32'(outs() & 6'b111110), 32'd0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule